// File: doc/BRIEF.md
# Video timing and border generator

This block produces the raster timing for a TV or VGA display. Two free-running counters walk the pixel clocks of a line and the lines of a field, and both wrap at programmed totals. Each line and each field is split into a sync region, a border region and a display window. The block drives horizontal and vertical sync and blanking. It outputs black during sync, the programmed border colour in the border, and pixels taken from a ready/valid stream inside the window. That stream comes from a separate fetch unit.

Options:
- Interlace, with a field flag that selects a per-field vertical window start.
- Scan doubling: the block flags repeated lines so that the fetch unit can resend a row.
- Horizontal pixel doubling (low resolution).
- A forced blank, which lets the border cover the whole picture.

Settings are written through a simple write port into shadow registers. They are copied to the active set only at the start of vertical retrace, so a field is never drawn with mixed settings.

Top module: `vtg_border`

## Requirements
- R1: During and right after reset every active setting is zero. With video output off, hsync and vsync are low, blank is high, rgb_out is zero, pix_ready is low and field is 0.
- R2: The horizontal position counts 0 to htot-1 per clock, and the line counts 0 to vtot-1 once per line. With video output on (sync-config bit 8), hsync is high while the position is outside [hstart, hstop), and vsync is high while the line is outside [vstart, vstop). Both are low when video output is off.
- R3: blank is high, and rgb_out is zero, whenever the position lies outside the border rectangle or video output is off.
- R4: Inside the border rectangle the window covers position >= window-h and line >= window-v. window-v is bits 15:0 of its register in field 0 and bits 31:16 in field 1. Outside the window the border colour is output and de is low.
- R5: Inside the window, de is high and pix_ready is high on each clock that takes a pixel. pix_data is output when pix_valid is high; otherwise the border colour is shown for that clock.
- R6: vblank_stb is high for exactly the first clock (position 0) of the line equal to vstop. In a stable mode it repeats every htot*vtot clocks.
- R7: Writes go to shadow registers and are copied into the active set only on a vblank_stb clock. A write in that same clock waits for the next strobe. Addresses: 0 totals (vtot 31:16, htot 15:0), 1 horizontal border (start 31:16, stop 15:0), 2 vertical border (same layout), 3 border colour, 4 window-h, 5 window-v, 6 window config, 7 mode, 8 sync config.
- R8: With interlace on (sync-config bit 4), field toggles on the last clock of each field. With interlace off, field becomes 0 at the next field end.
- R9: With scan doubling on (mode bit 1), line_repeat is high on window lines at an odd distance from window-v.
- R10: With low resolution on (window-config bit 0), pix_ready is high only at even offsets from window-h. At odd offsets the pixel accepted on the clock before is shown again.
- R11: With forced blank on (window-config bit 3), or with display enable off (mode bit 0 clear), the whole border rectangle shows the border colour, de is low and no pixel is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | AW | Register address |
| cfg_wdata | input | 32 | Register write data |
| pix_valid | input | 1 | Pixel stream valid |
| pix_data | input | PW | Pixel stream data |
| pix_ready | output | 1 | Pixel taken this clock |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| blank | output | 1 | Outside the border rectangle or video off |
| de | output | 1 | Window pixel being shown |
| rgb_out | output | PW | Output colour |
| vblank_stb | output | 1 | One-clock strobe at vertical retrace start |
| field | output | 1 | Current interlace field |
| line_repeat | output | 1 | Current window line repeats the previous row |

## Verification
The assertions assume that the programmed geometry is sane:
- the border stops do not exceed the totals;
- the window starts lie inside the border rectangle;
- the totals are at least a few clocks and lines, so that a strobe or a line end never falls on back-to-back clocks.

The stimulus meets these conditions in every mode. After reset it writes the totals before any other register, and each later mode change sends a complete, consistent set. Pixel validity is randomised with occasional gaps, so the underrun path is covered alongside normal delivery.

// File: rtl/vtg_border.sv
module vtg_border #(
  parameter int CW = 16,
  parameter int PW = 24,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [31:0]   cfg_wdata,
  input  logic          pix_valid,
  input  logic [PW-1:0] pix_data,
  output logic          pix_ready,
  output logic          hsync,
  output logic          vsync,
  output logic          blank,
  output logic          de,
  output logic [PW-1:0] rgb_out,
  output logic          vblank_stb,
  output logic          field,
  output logic          line_repeat
);
  localparam logic [AW-1:0] A_TOT  = AW'(0);
  localparam logic [AW-1:0] A_HBRD = AW'(1);
  localparam logic [AW-1:0] A_VBRD = AW'(2);
  localparam logic [AW-1:0] A_BCOL = AW'(3);
  localparam logic [AW-1:0] A_WINH = AW'(4);
  localparam logic [AW-1:0] A_WINV = AW'(5);
  localparam logic [AW-1:0] A_WCFG = AW'(6);
  localparam logic [AW-1:0] A_MODE = AW'(7);
  localparam logic [AW-1:0] A_SYNC = AW'(8);
  localparam int HI = 16;

  logic [CW-1:0] s_htot, s_vtot, s_hbs, s_hbe, s_vbs, s_vbe, s_wh, s_wv0, s_wv1;
  logic [CW-1:0] a_htot, a_vtot, a_hbs, a_hbe, a_vbs, a_vbe, a_wh, a_wv0, a_wv1;
  logic [PW-1:0] s_bcol, a_bcol, hold;
  logic s_lowres, s_fblank, s_disp, s_dbl, s_ven, s_intl;
  logic a_lowres, a_fblank, a_disp, a_dbl, a_ven, a_intl;
  logic [CW-1:0] hc, vc, wv;
  logic [CW:0]   hc_inc, vc_inc;
  logic hc_last, vc_last, hin, vin, rect, win, ph;
  logic unused_wdata;

  assign unused_wdata = ^cfg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_htot <= '0; s_vtot <= '0; s_hbs <= '0; s_hbe <= '0; s_vbs <= '0; s_vbe <= '0;
      s_wh <= '0; s_wv0 <= '0; s_wv1 <= '0; s_bcol <= '0;
      s_lowres <= 1'b0; s_fblank <= 1'b0; s_disp <= 1'b0; s_dbl <= 1'b0;
      s_ven <= 1'b0; s_intl <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_addr)
        A_TOT:  begin s_htot <= cfg_wdata[CW-1:0]; s_vtot <= cfg_wdata[HI +: CW]; end
        A_HBRD: begin s_hbe <= cfg_wdata[CW-1:0]; s_hbs <= cfg_wdata[HI +: CW]; end
        A_VBRD: begin s_vbe <= cfg_wdata[CW-1:0]; s_vbs <= cfg_wdata[HI +: CW]; end
        A_BCOL: s_bcol <= cfg_wdata[PW-1:0];
        A_WINH: s_wh <= cfg_wdata[CW-1:0];
        A_WINV: begin s_wv0 <= cfg_wdata[CW-1:0]; s_wv1 <= cfg_wdata[HI +: CW]; end
        A_WCFG: begin s_lowres <= cfg_wdata[0]; s_fblank <= cfg_wdata[3]; end
        A_MODE: begin s_disp <= cfg_wdata[0]; s_dbl <= cfg_wdata[1]; end
        A_SYNC: begin s_intl <= cfg_wdata[4]; s_ven <= cfg_wdata[8]; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_htot <= '0; a_vtot <= '0; a_hbs <= '0; a_hbe <= '0; a_vbs <= '0; a_vbe <= '0;
      a_wh <= '0; a_wv0 <= '0; a_wv1 <= '0; a_bcol <= '0;
      a_lowres <= 1'b0; a_fblank <= 1'b0; a_disp <= 1'b0; a_dbl <= 1'b0;
      a_ven <= 1'b0; a_intl <= 1'b0;
    end else if (vblank_stb) begin
      a_htot <= s_htot; a_vtot <= s_vtot; a_hbs <= s_hbs; a_hbe <= s_hbe;
      a_vbs <= s_vbs; a_vbe <= s_vbe; a_wh <= s_wh; a_wv0 <= s_wv0; a_wv1 <= s_wv1;
      a_bcol <= s_bcol; a_lowres <= s_lowres; a_fblank <= s_fblank; a_disp <= s_disp;
      a_dbl <= s_dbl; a_ven <= s_ven; a_intl <= s_intl;
    end
  end

  assign hc_inc  = {1'b0, hc} + 1'b1;
  assign vc_inc  = {1'b0, vc} + 1'b1;
  assign hc_last = hc_inc >= {1'b0, a_htot};
  assign vc_last = vc_inc >= {1'b0, a_vtot};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc <= '0; vc <= '0; field <= 1'b0; hold <= '0;
    end else begin
      if (pix_ready && pix_valid) hold <= pix_data;
      if (hc_last) begin
        hc <= '0;
        if (vc_last) begin
          vc <= '0;
          field <= a_intl & ~field;
        end else begin
          vc <= vc_inc[CW-1:0];
        end
      end else begin
        hc <= hc_inc[CW-1:0];
      end
    end
  end

  assign wv   = field ? a_wv1 : a_wv0;
  assign hin  = (hc >= a_hbs) && (hc < a_hbe);
  assign vin  = (vc >= a_vbs) && (vc < a_vbe);
  assign rect = a_ven && hin && vin;
  assign win  = rect && (hc >= a_wh) && (vc >= wv) && a_disp && !a_fblank;
  assign ph   = hc[0] ^ a_wh[0];

  assign vblank_stb  = (hc == '0) && (vc == a_vbe);
  assign hsync       = a_ven && !hin;
  assign vsync       = a_ven && !vin;
  assign blank       = !rect;
  assign de          = win;
  assign pix_ready   = win && !(a_lowres && ph);
  assign line_repeat = a_ven && a_dbl && vin && (vc >= wv) && (vc[0] ^ wv[0]);

  assign rgb_out = !rect              ? '0     :
                   !win               ? a_bcol :
                   (a_lowres && ph)   ? hold   :
                   pix_valid          ? pix_data : a_bcol;
endmodule

// File: rtl/vtg_border_chk.sv
module vtg_border_chk #(
  parameter int CW = 16,
  parameter int PW = 24
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  hsync,
  input logic                  vsync,
  input logic                  blank,
  input logic                  de,
  input logic                  pix_ready,
  input logic [PW-1:0]         rgb_out,
  input logic                  vblank_stb,
  input logic                  field,
  input logic                  hc_last,
  input logic                  vc_last,
  input logic                  lowres,
  input logic [9*CW+PW+5:0]    act_vec
);
  a_r3_blank_black: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> (rgb_out == '0));

  a_r2_sync_in_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (hsync || vsync) |-> blank);

  a_r5_ready_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |-> de);

  a_r10_lowres_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (lowres && pix_ready && !hc_last && !vblank_stb) |=> !pix_ready);

  a_r8_field_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (field != $past(field)) |-> $past(hc_last && vc_last));

  a_r7_apply_at_retrace: assert property (@(posedge clk) disable iff (!rst_n)
    (act_vec != $past(act_vec)) |-> $past(vblank_stb));
endmodule

bind vtg_border vtg_border_chk #(.CW(CW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync), .blank(blank), .de(de),
  .pix_ready(pix_ready), .rgb_out(rgb_out), .vblank_stb(vblank_stb), .field(field),
  .hc_last(hc_last), .vc_last(vc_last), .lowres(a_lowres),
  .act_vec({a_htot, a_vtot, a_hbs, a_hbe, a_vbs, a_vbe, a_wh, a_wv0, a_wv1, a_bcol,
            a_lowres, a_fblank, a_disp, a_dbl, a_ven, a_intl})
);

// File: tb/tb_vtg_border.sv
`timescale 1ns/1ps
module tb_vtg_border;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic pix_valid = 1'b0;
  logic [23:0] pix_data = '0;
  logic pix_ready, hsync, vsync, blank, de, vblank_stb, field, line_repeat;
  logic [23:0] rgb_out;

  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vtg_border dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready), .hsync(hsync),
    .vsync(vsync), .blank(blank), .de(de), .rgb_out(rgb_out), .vblank_stb(vblank_stb),
    .field(field), .line_repeat(line_repeat)
  );

  // behavioural reference
  bit [31:0] sh [9];
  bit [31:0] ac [9];
  int unsigned mhc, mvc;
  bit mfield;
  bit [23:0] mhold;
  bit e_hs, e_vs, e_blank, e_de, e_rdy, e_stb, e_rep;
  bit [23:0] e_rgb;

  task automatic model_eval();
    int unsigned htot_, hbs, hbe, vbs, vbe, wh, wv;
    bit ven, hin, vin, rect, win, ph, lr;
    hbs = ac[1][31:16]; hbe = ac[1][15:0];
    vbs = ac[2][31:16]; vbe = ac[2][15:0];
    wh = ac[4][15:0];
    wv = mfield ? ac[5][31:16] : ac[5][15:0];
    lr = ac[6][0]; ven = ac[8][8];
    htot_ = ac[0][15:0];
    hin = (mhc >= hbs) && (mhc < hbe);
    vin = (mvc >= vbs) && (mvc < vbe);
    rect = ven && hin && vin;
    win = rect && mhc >= wh && mvc >= wv && ac[7][0] && !ac[6][3];
    ph = win ? ((mhc - wh) % 2 == 1) : 1'b0;
    e_hs = ven && !hin;
    e_vs = ven && !vin;
    e_blank = !rect;
    e_de = win;
    e_rdy = win && !(lr && ph);
    e_stb = (mhc == 0) && (mvc == vbe);
    e_rep = ven && ac[7][1] && vin && mvc >= wv && ((mvc - wv) % 2 == 1);
    if (!rect) e_rgb = 0;
    else if (!win) e_rgb = ac[3][23:0];
    else if (lr && ph) e_rgb = mhold;
    else if (pix_valid) e_rgb = pix_data;
    else e_rgb = ac[3][23:0];
    if (htot_ == 0) e_stb = e_stb;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (sh[i]) begin sh[i] = 0; ac[i] = 0; end
      mhc = 0; mvc = 0; mfield = 0; mhold = 0;
    end else begin
      model_eval();
      if (e_rdy && pix_valid) mhold = pix_data;
      if (mhc + 1 >= ac[0][15:0]) begin
        mhc = 0;
        if (mvc + 1 >= ac[0][31:16]) begin
          mvc = 0;
          mfield = ac[8][4] ? !mfield : 1'b0;
        end else mvc++;
      end else mhc++;
      if (e_stb) foreach (ac[i]) ac[i] = sh[i];
      if (cfg_we && cfg_addr < 9) sh[cfg_addr] = cfg_wdata;
    end
  end

  task automatic chk(input string tag, input string nm, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    model_eval();
    chk("R2", "hsync", hsync, e_hs);
    chk("R2", "vsync", vsync, e_vs);
    chk("R3", "blank", blank, e_blank);
    chk("R4 R11", "de", de, e_de);
    chk("R5 R10 R11", "pix_ready", pix_ready, e_rdy);
    chk("R4 R5 R10 R11", "rgb_out", rgb_out, e_rgb);
    chk("R6 R7", "vblank_stb", vblank_stb, e_stb);
    chk("R8", "field", field, mfield);
    chk("R9", "line_repeat", line_repeat, e_rep);
  endtask

  task automatic cyc();
    @(negedge clk);
    #2;
    compare_all();
  endtask

  task automatic wr(input int a, input bit [31:0] d);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = d;
    cyc();
    cfg_we = 1'b0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      pix_valid = ($urandom % 10) != 0;
      pix_data = 24'($urandom);
      cyc();
    end
  endtask

  task automatic set_geom(input bit [31:0] tot, input bit [31:0] hb, input bit [31:0] vb,
                          input bit [31:0] wh, input bit [31:0] wv);
    wr(0, tot); wr(1, hb); wr(2, vb); wr(4, wh); wr(5, wv);
  endtask

  initial begin
    int cnt;
    repeat (3) cyc();
    // R1 reset state
    chk("R1", "hsync", hsync, 0);
    chk("R1", "vsync", vsync, 0);
    chk("R1", "blank", blank, 1);
    chk("R1", "rgb_out", rgb_out, 0);
    chk("R1", "pix_ready", pix_ready, 0);
    chk("R1", "field", field, 0);
    rst_n = 1'b1;
    cyc();
    chk("R1", "blank after release", blank, 1);

    // progressive, normal display
    set_geom({16'd20, 16'd40}, {16'd4, 16'd36}, {16'd2, 16'd18}, 32'd8, {16'd5, 16'd4});
    wr(3, 32'h123456); wr(6, 0); wr(7, 32'h1); wr(8, 32'h100);
    run(2500);

    // R6 strobe period in a stable mode
    while (!vblank_stb) cyc();
    cnt = 0;
    do begin cyc(); cnt++; end while (!vblank_stb);
    chk("R6", "strobe period", cnt, 800);

    // R7 border colour change mid-field waits for retrace
    run(200);
    wr(3, 32'hABCDEF);
    run(1700);

    // R8 interlace
    wr(8, 32'h110);
    run(2500);

    // R9 R10 scan doubling and low resolution
    wr(6, 32'h1); wr(7, 32'h3);
    run(2500);

    // R11 forced blank, then display disable
    wr(6, 32'h8);
    run(1700);
    wr(6, 32'h0); wr(7, 32'h0);
    run(1700);

    // video off, then a new geometry with interlace
    wr(7, 32'h1); wr(8, 32'h0);
    run(1700);
    set_geom({16'd16, 16'd30}, {16'd3, 16'd27}, {16'd1, 16'd14}, 32'd6, {16'd4, 16'd3});
    wr(8, 32'h110); wr(6, 32'h1); wr(7, 32'h3);
    run(3000);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule